// File: doc/BRIEF.md
# Serial Peripheral Word Shifter with Chip-Select Generation

This block is the serial engine of a four-wire SPI master. It takes 32-bit words from an external transmit queue, shifts a programmable number of bits (4 to 32) out on MOSI while capturing the same number of bits from MISO, and hands each received word to an external receive queue. Two static configuration words set the frame format and the pin behaviour: word length, which clock edge samples data, the idle level of SCLK, an internal loopback path, and four chip-select lines, each with its own active level and either automatic framing or a forced assertion.

Outgoing data is taken from the most significant end of the transmit word, so a byte to send sits in bits 31:24. Incoming data is right-justified, so an 8-bit word lands in bits 7:0 with zeros above it. A transfer session runs while `xfer_en` is high and words are available; the block raises a one-cycle error strobe when a word ends with the request still high and nothing left to send, and another when a received word has nowhere to go. SCLK runs at the system clock divided by `2*(half_div+1)`.

Top module: `spiw_master`

## Requirements
- R1: The word length is `fmt_cfg[4:0] + 1` bits; field values 0, 1 and 2 are treated as a 4-bit word, so exactly that many bits are shifted per word.
- R2: With `fmt_cfg[9]` = 1 the first bit is on MOSI before the first SCLK edge, data is sampled on edges leaving the idle level and changed on edges returning to it; with `fmt_cfg[9]` = 0 MOSI changes on edges leaving the idle level and is sampled on edges returning to it.
- R3: With `fmt_cfg[8]` = 1 the receive path takes the block's own MOSI and MISO is ignored; with it clear, MISO is sampled.
- R4: SCLK rests at the level of `pin_cfg[10]` whenever no word is being shifted, including after every word.
- R5: `pin_cfg[3:2]` selects line n of `cs_line`; `pin_cfg[4+n]` is the active level of line n; every line not being driven active sits at the inverse of its own level bit, and at most one line is active.
- R6: With `pin_cfg[11]` = 1 the selected line is held at its active level whether or not a word is in flight.
- R7: With `pin_cfg[8]` = 1 the selected line stays active across back-to-back words; with it clear the line is released for at least one cycle between words.
- R8: The first SCLK edge of a session comes `half_div+1` cycles after the chip select goes active; the chip select is released `half_div+2` cycles after the final SCLK edge.
- R9: Bits leave MSB-first starting at bit 31 of `tx_word`.
- R10: A received word is presented right-justified on `rx_word` with all bits above the word length zero, with a one-cycle `rx_push`.
- R11: If a word ends while `xfer_en` is high and `tx_empty` is high, `err_flags[0]` pulses for one cycle and the session ends.
- R12: If a word ends while `rx_full` is high, the word is dropped (no `rx_push`) and `err_flags[1]` pulses for one cycle.
- R13: `tx_pop` pulses once per word and only when `xfer_en` is high and `tx_empty` is low; no session starts otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_cfg | input | 10 | Frame format: [4:0] length minus one, [8] loopback, [9] sample on leading edge |
| pin_cfg | input | 12 | Pin control: [3:2] line select, [7:4] per-line active level, [8] hold select between words, [10] SCLK idle high, [11] force select |
| half_div | input | DIV_W | SCLK half period in system cycles, minus one |
| xfer_en | input | 1 | Transfer request level |
| tx_word | input | 32 | Head of the transmit queue |
| tx_empty | input | 1 | Transmit queue has no word |
| tx_pop | output | 1 | Take the head word of the transmit queue |
| rx_word | output | 32 | Received word, right-justified |
| rx_push | output | 1 | Write `rx_word` into the receive queue |
| rx_full | input | 1 | Receive queue cannot accept a word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_line | output | 4 | Chip-select lines |
| err_flags | output | 2 | One-cycle strobes: [1] receive overflow, [0] transmit starvation |

## Verification
The hardest situation to reach from the ports is the word boundary itself: the starvation and overflow strobes depend on what the request and queue flags are doing in the single cycle between the last SCLK edge and the next pop. The bench models both queues, so it can hold the request high while letting the transmit queue run dry, or hold the receive queue full across a whole word, and it removes the request only after the last pop so that normal sessions end without a spurious strobe. Serial data is captured by a monitor that decides from the configured phase and idle level which SCLK edges are sample edges, which lets loopback and MISO results be compared bit for bit.

// File: rtl/spiw_pkg.sv
// Shared definitions for the SPI word shifter: sequencer states, word size
// and the positions of the configuration bits that the logic decodes.
package spiw_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned MIN_BITS = 4;
    localparam int unsigned NUM_CS   = 4;
    localparam int unsigned SEL_W    = $clog2(NUM_CS);

    // fmt_cfg bit positions
    localparam int unsigned F_LEN_LSB = 0;
    localparam int unsigned F_LOOP    = 8;
    localparam int unsigned F_INFIRST = 9;

    // pin_cfg bit positions
    localparam int unsigned P_SEL_LSB = 2;
    localparam int unsigned P_POL_LSB = 4;
    localparam int unsigned P_HOLD    = 8;
    localparam int unsigned P_IDLEHI  = 10;
    localparam int unsigned P_FORCE   = 11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_WEND  = 2'd2,
        ST_TAIL  = 2'd3
    } spiw_state_e;

endpackage

// File: rtl/spiw_clkgen.sv
// Half-period timer and SCLK phase register.
// Assumes: the timer is held at zero whenever cnt_run is low, so every
// counted interval starts from a clean zero; edge_en is only raised on tick.
module spiw_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    input  logic             cnt_run,
    input  logic             edge_en,
    input  logic             idle_high,
    output logic             tick,
    output logic             sclk
);
    logic [DIV_W-1:0] cnt_q;
    logic             phase_q;

    assign tick = cnt_run && (cnt_q == half_div);
    assign sclk = phase_q ^ idle_high;

    // Count system cycles within one SCLK half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!cnt_run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Toggle the clock phase on every requested edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else if (edge_en) begin
            phase_q <= ~phase_q;
        end
    end

endmodule

// File: rtl/spiw_shifter.sv
// Transmit and receive shift registers for one word.
// Assumes: load, drive_en and sample_en come from one sequencer; drive_en
// and sample_en never coincide. Transmit data leaves from the MSB end; the
// receive register is cleared on load, so after N samples the word is
// right-justified with zeros above it.
module spiw_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         lead_bit,
    input  logic         drive_en,
    input  logic         sample_en,
    input  logic         in_bit,
    output logic         mosi,
    output logic [W-1:0] rx_data
);
    logic [W-1:0] tx_sh_q;
    logic [W-1:0] rx_sh_q;
    logic         mosi_q;

    assign mosi    = mosi_q;
    assign rx_data = rx_sh_q;

    // Load a new word, then shift out on drive edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh_q <= '0;
            mosi_q  <= 1'b0;
        end else if (load) begin
            if (lead_bit) begin
                mosi_q  <= load_word[W-1];
                tx_sh_q <= {load_word[W-2:0], 1'b0};
            end else begin
                mosi_q  <= 1'b0;
                tx_sh_q <= load_word;
            end
        end else if (drive_en) begin
            mosi_q  <= tx_sh_q[W-1];
            tx_sh_q <= {tx_sh_q[W-2:0], 1'b0};
        end
    end

    // Clear on load, then shift in on sample edges.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            rx_sh_q <= '0;
        end else if (sample_en) begin
            rx_sh_q <= {rx_sh_q[W-2:0], in_bit};
        end
    end

endmodule

// File: rtl/spiw_csgen.sv
// Chip-select line decoder.
// Assumes: pol[n] is the active level of line n; a line is active only
// when selected and either forced or inside a session.
module spiw_csgen
    import spiw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic [NUM_CS-1:0] pol,
    input  logic              force_on,
    input  logic              session,
    output logic [NUM_CS-1:0] cs_line
);
    // One driver per line: active level when chosen, inverse otherwise.
    for (genvar n = 0; n < NUM_CS; n++) begin : g_line
        always_comb begin
            if ((sel == SEL_W'(n)) && (force_on || session)) begin
                cs_line[n] = pol[n];
            end else begin
                cs_line[n] = ~pol[n];
            end
        end
    end

    AST_CS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~(cs_line ^ pol)));                                       // R5
    AST_CS_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        force_on |-> (cs_line[sel] == pol[sel]));                          // R6

endmodule

// File: rtl/spiw_master.sv
// SPI master word engine: pops a word, frames it with a chip select,
// shifts N bits at the programmed SCLK rate and pushes the received word.
// Assumes: fmt_cfg and pin_cfg are changed only while no session runs;
// queue flags are valid in the cycle they are used.
module spiw_master
    import spiw_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [9:0]        fmt_cfg,
    input  logic [11:0]       pin_cfg,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              xfer_en,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_empty,
    output logic              tx_pop,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_push,
    input  logic              rx_full,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_line,
    output logic [1:0]        err_flags
);
    localparam int EDGE_W = $clog2(2 * WORD_W);
    localparam int NB_W   = EDGE_W;

    spiw_state_e       state_q;
    logic [EDGE_W-1:0] edge_q;
    logic [EDGE_W-1:0] last_edge;
    logic [NB_W-1:0]   nbits_q;
    logic [NB_W-1:0]   nbits_req;
    logic [NB_W:0]     twice_n;
    logic              phase_q;
    logic              tick;
    logic              avail;
    logic              word_end;
    logic              is_last;
    logic              leading;
    logic              shift_tick;
    logic              sample_en;
    logic              drive_en;
    logic              in_bit;
    logic              cfg_unused;

    assign cfg_unused = ^{fmt_cfg[7:5], pin_cfg[9], pin_cfg[1:0]};

    // Requested word length with the lower bound applied.
    assign nbits_req = (fmt_cfg[F_LEN_LSB +: 5] < 5'(MIN_BITS - 1)) ?
                       NB_W'(MIN_BITS) : NB_W'(fmt_cfg[F_LEN_LSB +: 5]) + 1'b1;
    assign twice_n   = {nbits_q, 1'b0};
    assign last_edge = EDGE_W'(twice_n - 1'b1);

    // Queue handshakes and word-boundary strobes.
    assign avail     = xfer_en && !tx_empty;
    assign word_end  = (state_q == ST_WEND);
    assign tx_pop    = avail && ((state_q == ST_IDLE) ||
                                 (word_end && pin_cfg[P_HOLD]));
    assign rx_push   = word_end && !rx_full;
    assign err_flags = {word_end && rx_full, word_end && xfer_en && tx_empty};

    // Edge classification: even edges leave the idle level.
    assign shift_tick = (state_q == ST_SHIFT) && tick;
    assign leading    = ~edge_q[0];
    assign is_last    = (edge_q == last_edge);
    assign sample_en  = shift_tick && (phase_q ? leading : !leading);
    assign drive_en   = shift_tick && (phase_q ? (!leading && !is_last) : leading);
    assign in_bit     = fmt_cfg[F_LOOP] ? mosi : miso;

    // Session sequencer and per-word length/phase capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            edge_q  <= '0;
            nbits_q <= NB_W'(MIN_BITS);
            phase_q <= 1'b0;
        end else begin
            if (tx_pop) begin
                edge_q  <= '0;
                nbits_q <= nbits_req;
                phase_q <= fmt_cfg[F_INFIRST];
            end else if (shift_tick) begin
                edge_q  <= edge_q + 1'b1;
            end
            case (state_q)
                ST_IDLE:  if (tx_pop) state_q <= ST_SHIFT;
                ST_SHIFT: if (tick && is_last) state_q <= ST_WEND;
                ST_WEND:  state_q <= tx_pop ? ST_SHIFT : ST_TAIL;
                ST_TAIL:  if (tick) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    spiw_clkgen #(.DIV_W(DIV_W)) clkgen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_div  (half_div),
        .cnt_run   ((state_q == ST_SHIFT) || (state_q == ST_TAIL)),
        .edge_en   (shift_tick),
        .idle_high (pin_cfg[P_IDLEHI]),
        .tick      (tick),
        .sclk      (sclk)
    );

    spiw_shifter #(.W(WORD_W)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_pop),
        .load_word (tx_word),
        .lead_bit  (fmt_cfg[F_INFIRST]),
        .drive_en  (drive_en),
        .sample_en (sample_en),
        .in_bit    (in_bit),
        .mosi      (mosi),
        .rx_data   (rx_word)
    );

    spiw_csgen csgen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (pin_cfg[P_SEL_LSB +: SEL_W]),
        .pol      (pin_cfg[P_POL_LSB +: NUM_CS]),
        .force_on (pin_cfg[P_FORCE]),
        .session  (state_q != ST_IDLE),
        .cs_line  (cs_line)
    );

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (xfer_en && !tx_empty));                                 // R13
    AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);                                             // R12
    AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SHIFT) |-> (sclk == pin_cfg[P_IDLEHI]));            // R4
    AST_EDGE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (edge_q <= last_edge));                  // R1
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags != 2'b00) |=> (err_flags == 2'b00));                    // R11

endmodule

// File: tb/spiw_master_tb.sv
`timescale 1ns/1ps
module spiw_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  fmt_cfg = '0;
    logic [11:0] pin_cfg = '0;
    logic [7:0]  half_div = 8'd1;
    logic        xfer_en = 1'b0;
    logic [31:0] tx_word;
    logic        tx_empty;
    logic        tx_pop;
    logic [31:0] rx_word;
    logic        rx_push;
    logic        rx_full = 1'b0;
    logic        sclk;
    logic        mosi;
    logic        miso = 1'b1;
    logic [3:0]  cs_line;
    logic [1:0]  err_flags;

    always #2.5 clk = ~clk;

    spiw_master #(.DIV_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .fmt_cfg(fmt_cfg), .pin_cfg(pin_cfg),
        .half_div(half_div), .xfer_en(xfer_en), .tx_word(tx_word),
        .tx_empty(tx_empty), .tx_pop(tx_pop), .rx_word(rx_word),
        .rx_push(rx_push), .rx_full(rx_full), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_line(cs_line), .err_flags(err_flags)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc = 0;

    // Queue models
    logic [31:0] txq [8];
    int tx_wr = 0;
    int tx_rd = 0;
    int rx_cnt = 0;
    int under_cnt = 0;
    int over_cnt = 0;
    logic [31:0] rx_last = '0;
    assign tx_empty = (tx_wr == tx_rd);
    assign tx_word  = txq[tx_rd & 7];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tx_pop) tx_rd <= tx_rd + 1;
        if (rx_push) begin rx_last <= rx_word; rx_cnt <= rx_cnt + 1; end
        if (err_flags[0]) under_cnt <= under_cnt + 1;
        if (err_flags[1]) over_cnt <= over_cnt + 1;
    end

    // Bench copy of the configuration for the monitor
    logic       ifirst_b = 1'b0;
    logic       idle_b = 1'b0;
    logic [3:0] pol_b = '0;

    // Pin monitor
    logic [63:0] mosi_bits = '0;
    int mosi_n = 0;
    logic sclk_prev = 1'b0;
    logic act_prev = 1'b0;
    logic arm = 1'b0;
    int cs_on_cyc = 0;
    int last_sclk_cyc = 0;
    int first_gap = 0;
    int rel_gap = 0;
    int rel_cnt = 0;
    always @(negedge clk) begin
        logic any_act;
        logic lead;
        any_act = |(~(cs_line ^ pol_b));
        if (rst_n && (sclk !== sclk_prev)) begin
            if (arm) begin first_gap = cyc - cs_on_cyc; arm = 1'b0; end
            last_sclk_cyc = cyc;
            lead = (sclk != idle_b);
            if (ifirst_b == lead) begin
                mosi_bits = {mosi_bits[62:0], mosi};
                mosi_n++;
            end
        end
        if (rst_n && any_act && !act_prev) begin arm = 1'b1; cs_on_cyc = cyc; end
        if (rst_n && !any_act && act_prev) begin rel_gap = cyc - last_sclk_cyc; rel_cnt++; end
        sclk_prev = sclk;
        act_prev  = any_act;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [4:0] lenf, input logic ifirst, input logic loop,
                           input logic idle, input logic [1:0] sel, input logic [3:0] pol,
                           input logic hold, input logic frc);
        @(negedge clk);
        fmt_cfg  = {ifirst, loop, 3'b000, lenf};
        pin_cfg  = {frc, idle, 1'b0, hold, pol, sel, 2'b00};
        ifirst_b = ifirst;
        idle_b   = idle;
        pol_b    = pol;
        repeat (2) @(negedge clk);
    endtask

    task automatic push_word(input logic [31:0] w);
        txq[tx_wr & 7] = w;
        tx_wr++;
    endtask

    task automatic wait_empty();
        for (int k = 0; k < 5000 && !tx_empty; k++) @(negedge clk);
    endtask

    // Run a session of queued words; optionally keep the request high.
    task automatic run_session(input int nw, input logic keep_run);
        @(negedge clk);
        xfer_en = 1'b1;
        wait_empty();
        if (!keep_run) xfer_en = 1'b0;
        repeat (nw * 64 * (int'(half_div) + 1) + 40) @(negedge clk);
        xfer_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // {word, length field, input-first, loopback, idle-high}
    localparam logic [39:0] VEC [7] = '{
        {32'hA5C3_0F96, 5'd7,  1'b1, 1'b1, 1'b0},
        {32'h1234_5678, 5'd15, 1'b0, 1'b1, 1'b1},
        {32'hDEAD_BEEF, 5'd31, 1'b1, 1'b1, 1'b1},
        {32'hF000_0000, 5'd3,  1'b0, 1'b1, 1'b0},
        {32'h8000_0001, 5'd31, 1'b0, 1'b0, 1'b0},
        {32'h6B00_0000, 5'd1,  1'b1, 1'b1, 1'b0},
        {32'h3C5A_0000, 5'd11, 1'b1, 1'b0, 1'b1}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int rx0, rel0, und0, ovr0, mn0, rd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk("R5 reset cs idle", 64'(cs_line), 64'hF);
        chk("R4 reset sclk", 64'(sclk), 64'h0);
        chk("R13 reset no pop", 64'(tx_pop), 64'h0);
        chk("R11 reset no err", 64'(err_flags), 64'h0);

        // Table of formats: loopback/MISO result, MOSI stream, idle level
        foreach (VEC[i]) begin
            logic [31:0] w;
            logic [4:0]  lf;
            logic [63:0] exp_top, exp_rx, mask;
            int n;
            w  = VEC[i][39:8];
            lf = VEC[i][7:3];
            n  = (lf < 5'd3) ? 4 : int'(lf) + 1;
            mask    = (64'd1 << n) - 64'd1;
            exp_top = 64'(w) >> (32 - n);
            exp_rx  = VEC[i][1] ? exp_top : mask;
            set_cfg(lf, VEC[i][2], VEC[i][1], VEC[i][0], 2'd0, 4'b0000, 1'b1, 1'b0);
            mn0 = mosi_n;
            rx0 = rx_cnt;
            push_word(w);
            run_session(1, 1'b0);
            chk($sformatf("R10 R3 R1 vec%0d rx word", i), 64'(rx_last), exp_rx);
            chk($sformatf("R10 vec%0d one push", i), 64'(rx_cnt - rx0), 64'd1);
            chk($sformatf("R9 R2 vec%0d mosi bits", i), mosi_bits & mask, exp_top);
            chk($sformatf("R2 R1 vec%0d bit count", i), 64'(mosi_n - mn0), 64'(n));
            chk($sformatf("R4 vec%0d sclk idle", i), 64'(sclk), 64'(VEC[i][0]));
        end

        // Chip-select timing around a session
        half_div = 8'd2;
        set_cfg(5'd7, 1'b1, 1'b1, 1'b0, 2'd1, 4'b0000, 1'b1, 1'b0);
        push_word(32'h5A00_0000);
        run_session(1, 1'b0);
        chk("R8 cs to first edge", 64'(first_gap), 64'd3);
        chk("R8 last edge to release", 64'(rel_gap), 64'd4);
        half_div = 8'd1;

        // Line select and per-line active level
        set_cfg(5'd7, 1'b1, 1'b1, 1'b0, 2'd2, 4'b0110, 1'b1, 1'b0);
        chk("R5 idle lines", 64'(cs_line), 64'b1001);
        push_word(32'hC300_0000);
        @(negedge clk);
        xfer_en = 1'b1;
        repeat (6) @(negedge clk);
        chk("R5 selected line active", 64'(cs_line), 64'b1101);
        wait_empty();
        xfer_en = 1'b0;
        repeat (60) @(negedge clk);
        chk("R5 released after word", 64'(cs_line), 64'b1001);

        // Hold select across words
        set_cfg(5'd7, 1'b0, 1'b1, 1'b0, 2'd0, 4'b0000, 1'b1, 1'b0);
        rel0 = rel_cnt; rx0 = rx_cnt; und0 = under_cnt; rd0 = tx_rd;
        push_word(32'h1100_0000);
        push_word(32'hE700_0000);
        run_session(2, 1'b0);
        chk("R7 hold one release", 64'(rel_cnt - rel0), 64'd1);
        chk("R7 hold two words", 64'(rx_cnt - rx0), 64'd2);
        chk("R7 hold second word", 64'(rx_last), 64'hE7);
        chk("R13 one pop per word", 64'(tx_rd - rd0), 64'd2);
        chk("R11 no starvation when stopped", 64'(under_cnt - und0), 64'd0);

        set_cfg(5'd7, 1'b0, 1'b1, 1'b0, 2'd0, 4'b0000, 1'b0, 1'b0);
        rel0 = rel_cnt; rx0 = rx_cnt;
        push_word(32'h2200_0000);
        push_word(32'h3300_0000);
        run_session(2, 1'b0);
        chk("R7 framed two releases", 64'(rel_cnt - rel0), 64'd2);
        chk("R7 framed two words", 64'(rx_cnt - rx0), 64'd2);

        // Starvation: request held high with the queue dry
        set_cfg(5'd7, 1'b1, 1'b1, 1'b0, 2'd0, 4'b0000, 1'b1, 1'b0);
        rel0 = rel_cnt; und0 = under_cnt;
        push_word(32'h9900_0000);
        run_session(1, 1'b1);
        chk("R11 starvation strobe", 64'(under_cnt - und0), 64'd1);
        chk("R11 session ended", 64'(rel_cnt - rel0), 64'd1);

        // Receive overflow
        rx_full = 1'b1;
        rx0 = rx_cnt; ovr0 = over_cnt;
        push_word(32'h7700_0000);
        run_session(1, 1'b0);
        rx_full = 1'b0;
        chk("R12 word dropped", 64'(rx_cnt - rx0), 64'd0);
        chk("R12 overflow strobe", 64'(over_cnt - ovr0), 64'd1);

        // No start without request
        rd0 = tx_rd; mn0 = mosi_n;
        push_word(32'h4400_0000);
        repeat (20) @(negedge clk);
        chk("R13 no pop without request", 64'(tx_rd - rd0), 64'd0);
        chk("R13 no select without request", 64'(cs_line), 64'hF);
        run_session(1, 1'b0);
        chk("R13 popped on request", 64'(tx_rd - rd0), 64'd1);

        // Forced select
        set_cfg(5'd7, 1'b1, 1'b1, 1'b0, 2'd3, 4'b0000, 1'b1, 1'b1);
        chk("R6 forced low-active", 64'(cs_line), 64'b0111);
        set_cfg(5'd7, 1'b1, 1'b1, 1'b0, 2'd3, 4'b1001, 1'b1, 1'b1);
        chk("R6 forced high-active", 64'(cs_line), 64'b1110);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule